// File: doc/BRIEF.md
# Stepped Output Phase Offset Controller

This block holds the programmed phase offset for a family of generated output clocks and turns register writes into step commands for the logic that builds those clocks. A coarse offset byte moves the outputs in whole periods of a fast internal clock, about 61 ns per step. The coarse offset may only walk one step per write. Writing the current value plus one moves the clocks earlier by one step. Writing the current value minus one moves them later by one step. Any larger jump is refused.

A second byte holds a signed fine offset in two's complement. It is passed unchanged to a downstream delay line, and each unit is roughly 0.475 ns. An input of +8 gives about 3.8 ns of advance. The output clock divider and the delay line sit outside this block. The block only issues the single-cycle advance or retard request and the fine delay code.

A host writes bytes through a simple synchronous port with an address, a data byte and a write enable. Both offsets can be read back at any time through a combinational read port.

Top module: `phase_offset_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, both offsets read back as 00h, `fine_code` is 0, and `adv_pulse`, `ret_pulse` and `step_err` are low.
- R2: A write to address 0 (coarse) of the current value plus one, modulo 256, stores that value. In the cycle after the write cycle, `adv_pulse` is high for exactly one cycle and `ret_pulse` stays low.
- R3: A coarse write of the current value minus one, modulo 256, stores that value. In the cycle after the write cycle, `ret_pulse` is high for exactly one cycle and `adv_pulse` stays low.
- R4: The coarse step wraps. A write of 00h over FFh counts as one advance, and a write of FFh over 00h counts as one retard.
- R5: A coarse write equal to the current value is accepted. It gives no pulse and clears `step_err`.
- R6: A coarse write whose difference from the current value, modulo 256, is neither 0, +1 nor -1 leaves the coarse offset unchanged and gives no pulse. It raises `step_err` in the next cycle. `step_err` stays high until the next accepted coarse write clears it.
- R7: A write to address 1 (fine) stores any byte. `fine_code` presents it as a signed value from the next cycle on: 01h is +1, FFh is -1, 80h is -128.
- R8: Reads at address 0 return the coarse offset and reads at address 1 return the fine offset. Any other address reads as 00h, and writes to any other address change nothing.
- R9: `adv_pulse` and `ret_pulse` are never high in the same cycle.
- R10: Fine writes do not change the coarse offset or `step_err`, and they produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 2 | Write address: 0 coarse, 1 fine |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| adv_pulse | output | 1 | One-cycle request to move the outputs earlier by one coarse step |
| ret_pulse | output | 1 | One-cycle request to move the outputs later by one coarse step |
| step_err | output | 1 | Set by a refused coarse write |
| fine_code | output | 8 | Signed fine delay code for the delay line |

## Verification
A wrong stored coarse value does not stay hidden. It shows on the next readback, and it also changes how the next write is classified. A later write that should step would be refused or would pulse in the wrong direction, and this is visible one cycle after that write. A wrong direction or an extra pulse appears at the pulse outputs exactly one cycle after the write that caused it. A missed or late refusal shows on `step_err` in the same cycle. The bench therefore compares the pulse pins against an expected stream every cycle, and after each write it reads back both offsets and the error flag.

// File: rtl/phofs_pkg.sv
package phofs_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_ADV    = 2'd1,
        STEP_RET    = 2'd2,
        STEP_REJECT = 2'd3
    } step_kind_e;

    typedef struct packed {
        logic adv;
        logic ret;
    } step_req_t;

    // Classify a coarse write from the modular difference (new - current).
    function automatic step_kind_e classify_step(input logic is_zero,
                                                 input logic is_plus1,
                                                 input logic is_minus1);
        step_kind_e k;
        if (is_zero)        k = STEP_HOLD;
        else if (is_plus1)  k = STEP_ADV;
        else if (is_minus1) k = STEP_RET;
        else                k = STEP_REJECT;
        return k;
    endfunction

    function automatic step_req_t req_of(input step_kind_e k);
        step_req_t r;
        r.adv = (k == STEP_ADV);
        r.ret = (k == STEP_RET);
        return r;
    endfunction

endpackage

// File: rtl/phofs_regif.sv
module phofs_regif #(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int COARSE_ADDR = 0,
    parameter int FINE_ADDR   = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] coarse_q,
    input  logic [DATA_W-1:0] fine_q,
    output logic              coarse_we,
    output logic              fine_we,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_COARSE = ADDR_W'(COARSE_ADDR);
    localparam logic [ADDR_W-1:0] A_FINE   = ADDR_W'(FINE_ADDR);

    assign coarse_we = wr_en && (wr_addr == A_COARSE);
    assign fine_we   = wr_en && (wr_addr == A_FINE);

    always_comb begin
        if (rd_addr == A_COARSE)    rd_data = coarse_q;
        else if (rd_addr == A_FINE) rd_data = fine_q;
        else                        rd_data = '0;
    end
endmodule

// File: rtl/phofs_coarse.sv
module phofs_coarse
    import phofs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] coarse_q,
    output step_req_t         req_q,
    output logic              err_q
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ALL1 = '1;

    logic [DATA_W-1:0] diff;
    step_kind_e        kind;

    assign diff = wdata - coarse_q;
    assign kind = classify_step(diff == '0, diff == ONE, diff == ALL1);

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
            req_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            req_q <= '0;
            if (we) begin
                if (kind == STEP_REJECT) begin
                    err_q <= 1'b1;
                end else begin
                    coarse_q <= wdata;
                    req_q    <= req_of(kind);
                    err_q    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/phofs_fine.sv
module phofs_fine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] fine_q
);
    always_ff @(posedge clk) begin
        if (rst)     fine_q <= '0;
        else if (we) fine_q <= wdata;
    end
endmodule

// File: rtl/phase_offset_ctrl.sv
module phase_offset_ctrl
    import phofs_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int COARSE_ADDR = 0,
    parameter int FINE_ADDR   = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     adv_pulse,
    output logic                     ret_pulse,
    output logic                     step_err,
    output logic signed [DATA_W-1:0] fine_code
);
    logic              coarse_we, fine_we;
    logic [DATA_W-1:0] coarse_q, fine_q;
    step_req_t         req;

    phofs_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .COARSE_ADDR(COARSE_ADDR), .FINE_ADDR(FINE_ADDR)
    ) u_regif (
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .coarse_q(coarse_q), .fine_q(fine_q),
        .coarse_we(coarse_we), .fine_we(fine_we), .rd_data(rd_data)
    );

    phofs_coarse #(.DATA_W(DATA_W)) u_coarse (
        .clk(clk), .rst(rst), .we(coarse_we), .wdata(wr_data),
        .coarse_q(coarse_q), .req_q(req), .err_q(step_err)
    );

    phofs_fine #(.DATA_W(DATA_W)) u_fine (
        .clk(clk), .rst(rst), .we(fine_we), .wdata(wr_data),
        .fine_q(fine_q)
    );

    assign adv_pulse = req.adv;
    assign ret_pulse = req.ret;
    assign fine_code = signed'(fine_q);
endmodule

// File: rtl/phofs_checker.sv
module phofs_checker #(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int COARSE_ADDR = 0,
    parameter int FINE_ADDR   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              adv_pulse,
    input logic              ret_pulse,
    input logic              step_err,
    input logic [DATA_W-1:0] coarse_q,
    input logic [DATA_W-1:0] fine_q
);
    logic cw, fw;
    assign cw = wr_en && (wr_addr == ADDR_W'(COARSE_ADDR));
    assign fw = wr_en && (wr_addr == ADDR_W'(FINE_ADDR));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (coarse_q == '0 && fine_q == '0 && !adv_pulse && !ret_pulse && !step_err)); // R1
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
        adv_pulse |-> coarse_q == DATA_W'($past(coarse_q) + DATA_W'(1))); // R2
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !cw |=> (!adv_pulse && !ret_pulse)); // R2
    AST_RET_STEP: assert property (@(posedge clk) disable iff (rst)
        ret_pulse |-> coarse_q == DATA_W'($past(coarse_q) - DATA_W'(1))); // R3
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $rose(step_err) |-> ($stable(coarse_q) && !adv_pulse && !ret_pulse)); // R6
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(adv_pulse && ret_pulse)); // R9
    AST_FINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fw |=> $stable(fine_q)); // R8
    AST_FINE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (fw && !cw) |=> ($stable(coarse_q) && $stable(step_err))); // R10
endmodule

bind phase_offset_ctrl phofs_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .COARSE_ADDR(COARSE_ADDR), .FINE_ADDR(FINE_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .adv_pulse(adv_pulse), .ret_pulse(ret_pulse), .step_err(step_err),
    .coarse_q(coarse_q), .fine_q(fine_q)
);

// File: tb/tb_phase_offset_ctrl.sv
module tb_phase_offset_ctrl;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [1:0]        rd_addr = '0;
    logic [7:0]        rd_data;
    logic              adv_pulse, ret_pulse, step_err;
    logic signed [7:0] fine_code;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int       at;
        bit [1:0] code;
        string    tag;
    } exp_t;
    exp_t q[$];

    logic [7:0] m_coarse = 8'h00;
    logic [7:0] m_fine   = 8'h00;
    bit         m_err    = 1'b0;

    always #4 clk = ~clk;

    phase_offset_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .adv_pulse(adv_pulse),
        .ret_pulse(ret_pulse), .step_err(step_err), .fine_code(fine_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares the pulse pins against the expected stream every cycle.
    always @(negedge clk) begin
        if (!rst) begin
            bit [1:0] exp_code;
            string    tag;
            cyc++;
            exp_code = 2'b00;
            tag = "R10";
            if (q.size() > 0 && q[0].at == cyc) begin
                exp_code = q[0].code;
                tag = q[0].tag;
                void'(q.pop_front());
            end
            if (exp_code != 2'b00 || adv_pulse || ret_pulse) begin
                chk(tag, {ret_pulse, adv_pulse}, exp_code);
                chk("R9", int'(adv_pulse && ret_pulse), 0);
            end
        end
    end

    // Driver: one write, then idle. Pushes the expected pulse for the next cycle.
    task automatic do_wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        logic [7:0] diff;
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        e.at = cyc + 1; e.code = 2'b00; e.tag = tag;
        if (a == 2'd0) begin
            diff = d - m_coarse;
            if (diff == 8'h01)      begin e.code = 2'b01; m_coarse = d; m_err = 0; end
            else if (diff == 8'hFF) begin e.code = 2'b10; m_coarse = d; m_err = 0; end
            else if (diff == 8'h00) begin m_err = 0; end
            else                    begin m_err = 1; end
        end else if (a == 2'd1) begin
            m_fine = d;
        end
        if (e.code != 2'b00) q.push_back(e);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic check_state(input string tag);
        rd_addr = 2'd0; #1;
        chk({tag, " coarse"}, rd_data, m_coarse);
        rd_addr = 2'd1; #1;
        chk({tag, " fine"}, rd_data, m_fine);
        chk({tag, " fine_code"}, int'(fine_code), int'($signed(m_fine)));
        chk({tag, " err"}, step_err, m_err);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1");
        chk("R1 pulses", {ret_pulse, adv_pulse}, 0);
        #1; rst = 1'b0;
        @(negedge clk); #1;
        check_state("R1");

        // Four single advances
        for (int i = 1; i <= 4; i++) begin
            do_wr(2'd0, 8'(i), "R2");
            check_state("R2");
        end
        // Retard
        do_wr(2'd0, 8'h03, "R3");
        check_state("R3");
        // Jump of two is refused
        do_wr(2'd0, 8'h05, "R6");
        check_state("R6");
        do_wr(2'd0, 8'h80, "R6");
        check_state("R6 held");
        // Accepted advance clears the flag
        do_wr(2'd0, 8'h04, "R6");
        check_state("R6 clear");
        // Walk down through zero
        for (int v = 3; v >= 0; v--) begin
            do_wr(2'd0, 8'(v), "R3");
        end
        check_state("R3");
        do_wr(2'd0, 8'hFF, "R4");
        check_state("R4 retard wrap");
        do_wr(2'd0, 8'h00, "R4");
        check_state("R4 advance wrap");
        // Same value after an error
        do_wr(2'd0, 8'h07, "R6");
        check_state("R6");
        do_wr(2'd0, 8'h00, "R5");
        check_state("R5");
        // Fine offsets
        do_wr(2'd1, 8'h08, "R7");
        check_state("R7");
        do_wr(2'd1, 8'hFF, "R7");
        check_state("R7");
        do_wr(2'd1, 8'h80, "R7");
        check_state("R7");
        do_wr(2'd0, 8'h09, "R6");
        do_wr(2'd1, 8'h7F, "R10");
        check_state("R10");
        // Unmapped addresses
        do_wr(2'd2, 8'h55, "R8");
        do_wr(2'd3, 8'hAA, "R8");
        rd_addr = 2'd2; #1;
        chk("R8 addr2", rd_data, 0);
        rd_addr = 2'd3; #1;
        chk("R8 addr3", rd_data, 0);
        check_state("R8");

        repeat (4) @(negedge clk);
        chk("R2 queue drained", q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule